// File: doc/BRIEF.md
# Station Address Table Loader and Destination Filter

This block keeps a table of sixteen 48-bit station addresses, each held as three 16-bit words, and a 16-bit mask that enables entries one by one. A load engine fills the table from a list of descriptors in memory. It issues one 16-bit read at a time on a request/response port that uses valid/ready. Each descriptor names the entry it writes. Once the descriptors are done, one more word is read and becomes the enable mask.

The filter path is purely combinational. A 48-bit destination address is presented with a compare strobe. In the same cycle the block reports one of three results: a broadcast accept, an accept on the lowest-numbered enabled entry that matches, or a reject. Memory may hold off a request by keeping `rd_req_ready` low. The block raises `rd_rsp_ready` only while it waits for the data of its single outstanding read.

Top module: `addr_cam_filter`

## Requirements
- R1: A `load_start` pulse while idle latches `load_ptr`, `load_cnt` and `wide_mode` and raises `load_active`. A `load_start` while `load_active` is high is ignored: it changes neither the words read nor the table contents.
- R2: Descriptor word k (k = 0..3) is read at byte address pointer + 2k when `wide_mode` = 0, and at pointer + 4k when `wide_mode` = 1, in the order word 0, 1, 2, 3. While `rd_req_ready` is low, `rd_req_valid` and `rd_req_addr` stay unchanged.
- R3: Bits [3:0] of descriptor word 0 select the entry that is written, and its upper bits are ignored. Word 1 becomes address bits [47:32] of that entry, word 2 bits [31:16] and word 3 bits [15:0], with no byte swap.
- R4: After each descriptor the pointer advances by 8 bytes (`wide_mode` = 0) or 16 bytes (`wide_mode` = 1) and the count drops by one. Descriptors are read while the count is nonzero, so a load of N descriptors makes 4N+1 reads and its last read is at pointer + N*stride.
- R5: When the count is zero, including a load started with a count of zero, one word is read at the current pointer. Its bit i enables entry i. `load_active` then falls and `load_done` pulses high for exactly one cycle.
- R6: With `bcast_en` = 1 and `cmp_addr` all ones, the compare accepts with `cmp_bcast` = 1. This takes priority over the table.
- R7: Otherwise a compare accepts (`cmp_hit` = 1, `cmp_bcast` = 0) when `cmp_addr` equals an entry whose enable bit is set. `cmp_idx` gives the lowest such entry. Disabled entries never match.
- R8: If neither check matches, `cmp_reject` = 1 in the same cycle as `cmp_valid`, and exactly one of `cmp_hit` and `cmp_reject` is high. With `cmp_valid` low, `cmp_hit`, `cmp_bcast` and `cmp_reject` are all low.
- R9: After reset all entries are zero, the mask is zero, `load_active` is low and no read is requested.
- R10: Reads are issued only while loading, with at most one outstanding. `rd_rsp_ready` is high only while a response is awaited, and never in the same cycle as `rd_req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | Starts a table load when idle |
| load_ptr | input | 32 | Byte address of the first descriptor |
| load_cnt | input | 5 | Number of descriptors |
| wide_mode | input | 1 | 1: each word sits in a 4-byte slot; 0: 2-byte slot |
| load_active | output | 1 | High while a load runs |
| load_done | output | 1 | One-cycle pulse when the mask has been loaded |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 32 | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Block accepts read data |
| rd_rsp_data | input | 16 | Read data |
| bcast_en | input | 1 | Accept the all-ones address as broadcast |
| cmp_valid | input | 1 | Compare strobe |
| cmp_addr | input | 48 | Destination address to filter |
| cmp_hit | output | 1 | Address accepted |
| cmp_bcast | output | 1 | Accepted as broadcast |
| cmp_idx | output | 4 | Lowest matching enabled entry on a table hit, else 0 |
| cmp_reject | output | 1 | Address rejected |

## Verification
The assertions assume that memory answers every accepted read with exactly one response and never raises `rd_rsp_valid` without an outstanding request. The bench memory model keeps to this: it answers one cycle after each accepted request and holds the response until `rd_rsp_ready`. It also drops `rd_req_ready` on a repeating pattern to exercise back-pressure. The filter checks assume that table contents change only through loads. The bench therefore applies compare vectors only while no load runs.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int WORD_W    = 16;
  localparam int ADDR_W    = 48;
  localparam int WORDS_ENT = ADDR_W / WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_REQ  = 2'd1,
    LD_RSP  = 2'd2
  } ld_state_e;
endpackage

// File: rtl/cam_loader.sv
module cam_loader
  import cam_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int CNT_W = 5,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PTR_W-1:0] start_ptr,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             start_wide,
  output logic             active,
  output logic             done,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [PTR_W-1:0] req_addr,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [IDX_W-1:0] rsp_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [1:0]       wr_sel,
  output logic             mask_we
);
  ld_state_e        state;
  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       wsel;
  logic             mask_ph;
  logic             wide_q;
  logic [IDX_W-1:0] idx_q;
  logic [PTR_W-1:0] offs;
  logic [PTR_W-1:0] stride;
  logic             take;

  assign offs      = wide_q ? PTR_W'({wsel, 2'b00}) : PTR_W'({wsel, 1'b0});
  assign stride    = wide_q ? PTR_W'(16) : PTR_W'(8);
  assign req_addr  = ptr + offs;
  assign req_valid = (state == LD_REQ);
  assign rsp_ready = (state == LD_RSP);
  assign active    = (state != LD_IDLE);
  assign take      = (state == LD_RSP) && rsp_valid;

  assign wr_en   = take && !mask_ph && (wsel != 2'd0);
  assign wr_idx  = idx_q;
  assign wr_sel  = wsel - 2'd1;
  assign mask_we = take && mask_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= LD_IDLE;
      ptr     <= '0;
      cnt     <= '0;
      wsel    <= '0;
      mask_ph <= 1'b0;
      wide_q  <= 1'b0;
      idx_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        LD_IDLE: begin
          if (start) begin
            ptr     <= start_ptr;
            cnt     <= start_cnt;
            wide_q  <= start_wide;
            wsel    <= '0;
            mask_ph <= (start_cnt == '0);
            state   <= LD_REQ;
          end
        end
        LD_REQ: begin
          if (req_ready) state <= LD_RSP;
        end
        LD_RSP: begin
          if (rsp_valid) begin
            if (mask_ph) begin
              state <= LD_IDLE;
              done  <= 1'b1;
            end else begin
              if (wsel == 2'd0) idx_q <= rsp_idx;
              if (wsel == 2'd3) begin
                wsel    <= '0;
                ptr     <= ptr + stride;
                cnt     <= cnt - 1'b1;
                mask_ph <= (cnt == CNT_W'(1));
              end else begin
                wsel <= wsel + 2'd1;
              end
              state <= LD_REQ;
            end
          end
        end
        default: state <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cam_store.sv
module cam_store
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [1:0]                      wr_sel,
  input  word_t                           wr_data,
  input  logic                            mask_we,
  output logic [ENTRIES-1:0][ADDR_W-1:0]  entries,
  output logic [ENTRIES-1:0]              enables
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entries[e] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        unique case (wr_sel)
          2'd0:    entries[e][47:32] <= wr_data;
          2'd1:    entries[e][31:16] <= wr_data;
          default: entries[e][15:0]  <= wr_data;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       enables <= '0;
    else if (mask_we) enables <= wr_data[ENTRIES-1:0];
  end
endmodule

// File: rtl/cam_match.sv
module cam_match
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0][ADDR_W-1:0] entries,
  input  logic [ENTRIES-1:0]             enables,
  input  logic                           bcast_en,
  input  logic                           cmp_valid,
  input  logic [ADDR_W-1:0]              cmp_addr,
  output logic                           cmp_hit,
  output logic                           cmp_bcast,
  output logic [IDX_W-1:0]               cmp_idx,
  output logic                           cmp_reject
);
  logic [ENTRIES-1:0] eq;
  logic [IDX_W-1:0]   low_idx;
  logic               bc_hit;
  logic               tbl_hit;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign eq[e] = enables[e] && (entries[e] == cmp_addr);
  end

  always_comb begin
    low_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) low_idx = IDX_W'(i);
    end
  end

  assign bc_hit     = bcast_en && (&cmp_addr);
  assign tbl_hit    = |eq;
  assign cmp_hit    = cmp_valid && (bc_hit || tbl_hit);
  assign cmp_bcast  = cmp_valid && bc_hit;
  assign cmp_reject = cmp_valid && !(bc_hit || tbl_hit);
  assign cmp_idx    = (cmp_valid && !bc_hit && tbl_hit) ? low_idx : '0;
endmodule

// File: rtl/addr_cam_filter.sv
module addr_cam_filter
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PTR_W   = 32,
  parameter int CNT_W   = 5,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_start,
  input  logic [PTR_W-1:0]  load_ptr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              wide_mode,
  output logic              load_active,
  output logic              load_done,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [PTR_W-1:0]  rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [WORD_W-1:0] rd_rsp_data,
  input  logic              bcast_en,
  input  logic              cmp_valid,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic              cmp_hit,
  output logic              cmp_bcast,
  output logic [IDX_W-1:0]  cmp_idx,
  output logic              cmp_reject
);
  logic                           wr_en;
  logic [IDX_W-1:0]               wr_idx;
  logic [1:0]                     wr_sel;
  logic                           mask_we;
  logic [ENTRIES-1:0][ADDR_W-1:0] entries;
  logic [ENTRIES-1:0]             enables;

  cam_loader #(.PTR_W(PTR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (load_start),
    .start_ptr  (load_ptr),
    .start_cnt  (load_cnt),
    .start_wide (wide_mode),
    .active     (load_active),
    .done       (load_done),
    .req_valid  (rd_req_valid),
    .req_ready  (rd_req_ready),
    .req_addr   (rd_req_addr),
    .rsp_valid  (rd_rsp_valid),
    .rsp_ready  (rd_rsp_ready),
    .rsp_idx    (rd_rsp_data[IDX_W-1:0]),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_sel     (wr_sel),
    .mask_we    (mask_we)
  );

  cam_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_sel  (wr_sel),
    .wr_data (rd_rsp_data),
    .mask_we (mask_we),
    .entries (entries),
    .enables (enables)
  );

  cam_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
    .entries    (entries),
    .enables    (enables),
    .bcast_en   (bcast_en),
    .cmp_valid  (cmp_valid),
    .cmp_addr   (cmp_addr),
    .cmp_hit    (cmp_hit),
    .cmp_bcast  (cmp_bcast),
    .cmp_idx    (cmp_idx),
    .cmp_reject (cmp_reject)
  );
endmodule

// File: rtl/addr_cam_filter_chk.sv
module addr_cam_filter_chk #(
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_active,
  input logic             load_done,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic [PTR_W-1:0] rd_req_addr,
  input logic             rd_rsp_ready,
  input logic             bcast_en,
  input logic             cmp_valid,
  input logic [47:0]      cmp_addr,
  input logic             cmp_hit,
  input logic             cmp_bcast,
  input logic             cmp_reject
);
  a_r5_done_ends_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (!load_active && $past(load_active)));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  a_r10_req_while_loading: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> load_active);

  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));

  a_r8_hit_xor_reject: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> (cmp_hit != cmp_reject));

  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |-> (!cmp_hit && !cmp_bcast && !cmp_reject));

  a_r6_bcast_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && bcast_en && (&cmp_addr)) |-> (cmp_hit && cmp_bcast));
endmodule

bind addr_cam_filter addr_cam_filter_chk #(.PTR_W(PTR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_active  (load_active),
  .load_done    (load_done),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_rsp_ready (rd_rsp_ready),
  .bcast_en     (bcast_en),
  .cmp_valid    (cmp_valid),
  .cmp_addr     (cmp_addr),
  .cmp_hit      (cmp_hit),
  .cmp_bcast    (cmp_bcast),
  .cmp_reject   (cmp_reject)
);

// File: tb/tb_addr_cam_filter.sv
`timescale 1ns/1ps
module tb_addr_cam_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_start = 1'b0;
  logic [31:0] load_ptr = '0;
  logic [4:0]  load_cnt = '0;
  logic        wide_mode = 1'b0;
  logic        load_active, load_done;
  logic        rd_req_valid, rd_rsp_ready;
  logic        rd_req_ready, rd_rsp_valid;
  logic [31:0] rd_req_addr;
  logic [15:0] rd_rsp_data;
  logic        bcast_en = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [47:0] cmp_addr = '0;
  logic        cmp_hit, cmp_bcast, cmp_reject;
  logic [3:0]  cmp_idx;

  int n_chk = 0;
  int n_bad = 0;
  int req_cnt = 0;
  logic [31:0] last_addr = '0;
  logic [15:0] mem [0:255];
  logic [2:0]  stall = '0;

  always #10 clk = ~clk;

  addr_cam_filter dut (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_ptr(load_ptr),
    .load_cnt(load_cnt), .wide_mode(wide_mode), .load_active(load_active),
    .load_done(load_done), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .bcast_en(bcast_en), .cmp_valid(cmp_valid),
    .cmp_addr(cmp_addr), .cmp_hit(cmp_hit), .cmp_bcast(cmp_bcast),
    .cmp_idx(cmp_idx), .cmp_reject(cmp_reject)
  );

  // memory model: one response per accepted request, ready stalls periodically
  always @(posedge clk) begin
    if (!rst_n) begin
      rd_req_ready <= 1'b0;
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
      stall        <= '0;
    end else begin
      stall        <= stall + 3'd1;
      rd_req_ready <= stall[0] | stall[2];
      if (rd_rsp_valid && rd_rsp_ready) rd_rsp_valid <= 1'b0;
      if (rd_req_valid && rd_req_ready) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= mem[rd_req_addr[8:1]];
        req_cnt      <= req_cnt + 1;
        last_addr    <= rd_req_addr;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input int addr, input logic [15:0] v);
    mem[addr >> 1] = v;
  endtask

  task automatic start_load(input logic [31:0] p, input logic [4:0] c, input logic w);
    @(negedge clk);
    load_ptr = p; load_cnt = c; wide_mode = w; load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (load_done) seen = 1;
    end
    check({tag, " R5 done pulse"}, 64'(seen), 64'd1);
    check({tag, " R5 active cleared"}, 64'(load_active), 64'd0);
  endtask

  task automatic compare(input string tag, input logic bc, input logic [47:0] a,
                         input logic hit, input logic isb, input logic [3:0] idx);
    @(negedge clk);
    bcast_en = bc; cmp_addr = a; cmp_valid = 1'b1;
    #2;
    check({tag, " hit"}, 64'(cmp_hit), 64'(hit));
    check({tag, " bcast"}, 64'(cmp_bcast), 64'(isb));
    check({tag, " reject"}, 64'(cmp_reject), 64'(!hit));
    if (hit && !isb) check({tag, " idx"}, 64'(cmp_idx), 64'(idx));
    @(negedge clk);
    cmp_valid = 1'b0; bcast_en = 1'b0;
  endtask

  // {bcast_en, address, hit, bcast, idx} after the first narrow load
  localparam logic [54:0] VEC [0:8] = '{
    {1'b1, 48'hFFFF_FFFF_FFFF, 1'b1, 1'b1, 4'd0},
    {1'b0, 48'hFFFF_FFFF_FFFF, 1'b1, 1'b0, 4'd15},
    {1'b0, 48'h0011_2233_4455, 1'b1, 1'b0, 4'd5},
    {1'b1, 48'h0011_2233_4455, 1'b1, 1'b0, 4'd5},
    {1'b0, 48'h0200_0000_0001, 1'b1, 1'b0, 4'd0},
    {1'b0, 48'h1234_5678_9ABC, 1'b0, 1'b0, 4'd0},
    {1'b0, 48'h0011_2233_4454, 1'b0, 1'b0, 4'd0},
    {1'b0, 48'h0000_0000_0000, 1'b0, 1'b0, 4'd0},
    {1'b1, 48'hFFFF_FFFF_FFFE, 1'b0, 1'b0, 4'd0}
  };

  bit finished = 0;

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    for (int i = 0; i < 256; i++) mem[i] = 16'hA5A5 ^ 16'(i * 16'h0101);
    // narrow list at 0x040: four descriptors, mask at 0x060
    poke(16'h040, 16'hFFF5); poke(16'h042, 16'h0011); poke(16'h044, 16'h2233); poke(16'h046, 16'h4455);
    poke(16'h048, 16'h0000); poke(16'h04A, 16'h0200); poke(16'h04C, 16'h0000); poke(16'h04E, 16'h0001);
    poke(16'h050, 16'h003F); poke(16'h052, 16'hFFFF); poke(16'h054, 16'hFFFF); poke(16'h056, 16'hFFFF);
    poke(16'h058, 16'h0009); poke(16'h05A, 16'h1234); poke(16'h05C, 16'h5678); poke(16'h05E, 16'h9ABC);
    poke(16'h060, 16'h8021);
    // wide list at 0x100: two descriptors in 4-byte slots, mask at 0x120
    poke(16'h100, 16'h0009); poke(16'h104, 16'hAAAA); poke(16'h108, 16'hBBBB); poke(16'h10C, 16'hCCCC);
    poke(16'h110, 16'h0000); poke(16'h114, 16'h0102); poke(16'h118, 16'h0304); poke(16'h11C, 16'h0506);
    poke(16'h120, 16'h0201);
    // mask-only load word
    poke(16'h180, 16'h0221);
    // duplicate entry 12, mask at 0x1C8
    poke(16'h1C0, 16'h000C); poke(16'h1C2, 16'hAAAA); poke(16'h1C4, 16'hBBBB); poke(16'h1C6, 16'hCCCC);
    poke(16'h1C8, 16'h1201);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 active after reset", 64'(load_active), 64'd0);
    check("R9 no request after reset", 64'(rd_req_valid), 64'd0);
    compare("R9 zero address rejected", 1'b0, 48'h0, 1'b0, 1'b0, 4'd0);
    compare("R6 bcast with empty table", 1'b1, 48'hFFFF_FFFF_FFFF, 1'b1, 1'b1, 4'd0);

    // narrow load with an extra start mid-load (R1)
    base = req_cnt;
    start_load(32'h040, 5'd4, 1'b0);
    check("R1 active after start", 64'(load_active), 64'd1);
    repeat (6) @(negedge clk);
    load_ptr = 32'h000; load_cnt = 5'd1; load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    wait_done("narrow");
    check("R4 R2 narrow read count", 64'(req_cnt - base), 64'd17);
    check("R4 narrow last address", 64'(last_addr), 64'h060);

    for (int i = 0; i < 9; i++) begin
      compare($sformatf("R6 R7 R8 R3 vector %0d", i), VEC[i][54], VEC[i][53:6],
              VEC[i][5], VEC[i][4], VEC[i][3:0]);
    end

    // R8 no strobe -> quiet
    @(negedge clk);
    cmp_addr = 48'h0011_2233_4455; cmp_valid = 1'b0; #2;
    check("R8 quiet hit", 64'(cmp_hit), 64'd0);
    check("R8 quiet reject", 64'(cmp_reject), 64'd0);

    // wide load
    base = req_cnt;
    start_load(32'h100, 5'd2, 1'b1);
    wait_done("wide");
    check("R2 R4 wide read count", 64'(req_cnt - base), 64'd9);
    check("R4 wide last address", 64'(last_addr), 64'h120);
    compare("R2 wide entry 9", 1'b0, 48'hAAAA_BBBB_CCCC, 1'b1, 1'b0, 4'd9);
    compare("R2 wide entry 0", 1'b0, 48'h0102_0304_0506, 1'b1, 1'b0, 4'd0);
    compare("R7 entry 5 disabled", 1'b0, 48'h0011_2233_4455, 1'b0, 1'b0, 4'd0);
    compare("R3 entry 0 overwritten", 1'b0, 48'h0200_0000_0001, 1'b0, 1'b0, 4'd0);

    // zero-count load: mask only
    base = req_cnt;
    start_load(32'h180, 5'd0, 1'b0);
    wait_done("mask only");
    check("R5 mask-only read count", 64'(req_cnt - base), 64'd1);
    check("R5 mask-only address", 64'(last_addr), 64'h180);
    compare("R5 entry 5 re-enabled", 1'b0, 48'h0011_2233_4455, 1'b1, 1'b0, 4'd5);

    // duplicate address in entries 9 and 12
    base = req_cnt;
    start_load(32'h1C0, 5'd1, 1'b0);
    wait_done("dup");
    check("R4 dup read count", 64'(req_cnt - base), 64'd5);
    compare("R7 lowest index wins", 1'b0, 48'hAAAA_BBBB_CCCC, 1'b1, 1'b0, 4'd9);
    compare("R7 entry 5 disabled again", 1'b0, 48'h0011_2233_4455, 1'b0, 1'b0, 4'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule